// File: doc/BRIEF.md
# Serial Flash Single-Byte Read Engine

This block fetches data from an attached serial NOR flash device one byte per command. Software loads a start address and a read opcode into byte-wide registers, picks a lane mode and an address width, and optionally turns on fast read. It then writes the read command code. The engine lowers chip select and sends the opcode and the address serially, most significant bit first, on lane 0. When fast read is on, it adds dummy clocks. It then gathers one byte on one, two or four lanes and places it in a read-data register.

After each completed command the internal address advances by one. Repeated read commands therefore walk through consecutive flash bytes without reloading the address. Software detects completion by polling a busy bit in the command register. The serial clock is the system clock divided down by a parameter and runs in SPI mode 0.

Top module: `sfr_read_engine`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, all lane output enables are off, and the command register (offset 0x00) reads 0x00.
- R2: Writing 0x81 to the command register while idle starts one single-byte read. Any other written value starts nothing, and chip select stays high.
- R3: Command register bit 0 reads 1 from the cycle after the start write until the read completes, and reads 0 afterwards. The received byte is then readable at offset 0x03.
- R4: The opcode comes from offset 0x04 when mode bit 2 is clear and from offset 0x05 when mode bit 2 is set. It is sent as the first 8 clocks, most significant bit first, on lane 0.
- R5: The mode register is at offset 0x01. When bit 2 is set, data is taken on four lanes per clock with lane 3 most significant, whatever bit 0 holds. Otherwise, when bit 0 is set, data is taken on two lanes per clock with lane 1 most significant. Otherwise data is taken one bit per clock on lane 1. Bits are received most significant first.
- R6: The address is written as four bytes at offsets 0x08 to 0x0B, least significant byte first. Mode bit 4 set sends all 32 address bits; clear sends the low 24 bits. The address follows the opcode on lane 0, most significant bit first.
- R7: Bit 0 of the configuration register (offset 0x02) inserts 8 dummy clocks between address and data. One command gives exactly 8 + address bits + dummy clocks + 8/lanes rising serial-clock edges.
- R8: When a read completes, the 32-bit address register increments by one with carry, so back-to-back commands return consecutive bytes. The new value reads back at offsets 0x08 to 0x0B.
- R9: The serial clock idles low and is low whenever chip select is high. Chip select stays low for the whole command. Lane 0 output enable is asserted only during the opcode and address clocks, and no other lane is ever driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register offset |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data, combinational on offset |
| flash_sck_o | output | 1 | Serial clock to flash |
| flash_cs_n_o | output | 1 | Active-low chip select |
| flash_io_o | output | 4 | Lane output values |
| flash_io_oe_o | output | 4 | Lane output enables |
| flash_io_i | input | 4 | Lane input values |

## Verification
A wrong clock-cycle count or phase boundary shows up at the ports when chip select rises at the end of that same command. In that case the number of serial-clock edges, the bits captured on lane 0, or the byte assembled from the lanes no longer match the mode. A corrupted address register stays hidden until the next command, whose address phase then carries the wrong value, and it also shows when the address bytes are read back. A stuck busy flag shows within a few cycles, either as a command register that never clears or as chip select staying low with no clock activity.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  typedef enum logic [1:0] {
    LANE_X1 = 2'd0,
    LANE_X2 = 2'd1,
    LANE_X4 = 2'd2
  } lane_e;

  localparam logic [7:0] CMD_PIO_RD = 8'h81;

  localparam logic [7:0] OFS_CMD   = 8'h00;
  localparam logic [7:0] OFS_MODE  = 8'h01;
  localparam logic [7:0] OFS_CFG   = 8'h02;
  localparam logic [7:0] OFS_RDATA = 8'h03;
  localparam logic [7:0] OFS_OPA   = 8'h04;
  localparam logic [7:0] OFS_OPB   = 8'h05;
  localparam logic [5:0] OFS_ADRW  = 6'h02;  // offsets 0x08..0x0B

  localparam logic [6:0] DUMMY_CLKS = 7'd8;
  localparam logic [6:0] OPC_CLKS   = 7'd8;
endpackage

// File: rtl/sfr_tick.sv
module sfr_tick #(
  parameter int unsigned DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (cnt_q == LAST);

  always_comb begin
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sfr_regs.sv
module sfr_regs
  import sfr_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_we_i,
  input  logic [7:0]    bus_addr_i,
  input  logic [7:0]    bus_wdata_i,
  output logic [7:0]    bus_rdata_o,
  input  logic          busy_i,
  input  logic          done_i,
  input  logic [7:0]    rx_byte_i,
  output logic          start_o,
  output lane_e         lane_o,
  output logic          addr4_o,
  output logic          fast_o,
  output logic [7:0]    opcode_o,
  output logic [AW-1:0] addr_o
);
  localparam int unsigned NB = AW / 8;

  logic [7:0]    mode_q, mode_d, cfg_q, cfg_d, opa_q, opa_d, opb_q, opb_d;
  logic [7:0]    rdata_q, rdata_d;
  logic [AW-1:0] addr_q, addr_d;

  assign start_o  = bus_we_i && (bus_addr_i == OFS_CMD) &&
                    (bus_wdata_i == CMD_PIO_RD) && !busy_i;
  assign lane_o   = mode_q[2] ? LANE_X4 : (mode_q[0] ? LANE_X2 : LANE_X1);
  assign addr4_o  = mode_q[4];
  assign fast_o   = cfg_q[0];
  assign opcode_o = mode_q[2] ? opb_q : opa_q;
  assign addr_o   = addr_q;

  always_comb begin
    mode_d  = mode_q;
    cfg_d   = cfg_q;
    opa_d   = opa_q;
    opb_d   = opb_q;
    rdata_d = rdata_q;
    addr_d  = addr_q;
    if (bus_we_i) begin
      case (bus_addr_i)
        OFS_MODE: mode_d = bus_wdata_i;
        OFS_CFG:  cfg_d  = bus_wdata_i;
        OFS_OPA:  opa_d  = bus_wdata_i;
        OFS_OPB:  opb_d  = bus_wdata_i;
        default: ;
      endcase
    end
    if (done_i) begin
      rdata_d = rx_byte_i;
      addr_d  = addr_q + 1'b1;
    end else if (bus_we_i && bus_addr_i[7:2] == OFS_ADRW) begin
      for (int i = 0; i < NB; i++)
        if (bus_addr_i[1:0] == 2'(i)) addr_d[8*i +: 8] = bus_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      cfg_q   <= '0;
      opa_q   <= '0;
      opb_q   <= '0;
      rdata_q <= '0;
      addr_q  <= '0;
    end else begin
      mode_q  <= mode_d;
      cfg_q   <= cfg_d;
      opa_q   <= opa_d;
      opb_q   <= opb_d;
      rdata_q <= rdata_d;
      addr_q  <= addr_d;
    end
  end

  always_comb begin
    bus_rdata_o = 8'h00;
    case (bus_addr_i)
      OFS_CMD:   bus_rdata_o = {7'b0, busy_i};
      OFS_MODE:  bus_rdata_o = mode_q;
      OFS_CFG:   bus_rdata_o = cfg_q;
      OFS_RDATA: bus_rdata_o = rdata_q;
      OFS_OPA:   bus_rdata_o = opa_q;
      OFS_OPB:   bus_rdata_o = opb_q;
      default: begin
        if (bus_addr_i[7:2] == OFS_ADRW)
          for (int i = 0; i < NB; i++)
            if (bus_addr_i[1:0] == 2'(i)) bus_rdata_o = addr_q[8*i +: 8];
      end
    endcase
  end
endmodule

// File: rtl/sfr_xfer.sv
module sfr_xfer
  import sfr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        tick_i,
  input  lane_e       lane_i,
  input  logic        addr4_i,
  input  logic        fast_i,
  input  logic [7:0]  opcode_i,
  input  logic [31:0] addr_i,
  input  logic [3:0]  io_in_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [7:0]  rx_byte_o,
  output logic        sck_o,
  output logic        cs_n_o,
  output logic [3:0]  io_out_o,
  output logic [3:0]  io_oe_o
);
  logic        busy_q, busy_d, sck_q, sck_d, addr4_q, addr4_d, fast_q, fast_d;
  lane_e       lane_q, lane_d;
  logic [6:0]  cyc_q, cyc_d;
  logic [39:0] tx_q, tx_d;
  logic [7:0]  rx_q, rx_d;
  logic [6:0]  abits, dstart, dcyc, last;
  logic        rise, fall;

  assign abits  = addr4_q ? 7'd32 : 7'd24;
  assign dstart = OPC_CLKS + abits + (fast_q ? DUMMY_CLKS : 7'd0);
  assign dcyc   = (lane_q == LANE_X4) ? 7'd2 : ((lane_q == LANE_X2) ? 7'd4 : 7'd8);
  assign last   = dstart + dcyc - 7'd1;
  assign rise   = busy_q && tick_i && !sck_q;
  assign fall   = busy_q && tick_i && sck_q;

  assign done_o    = fall && (cyc_q == last);
  assign busy_o    = busy_q;
  assign cs_n_o    = !busy_q;
  assign sck_o     = sck_q;
  assign rx_byte_o = rx_q;
  assign io_out_o  = {3'b000, tx_q[39]};
  assign io_oe_o   = {3'b000, busy_q && (cyc_q < OPC_CLKS + abits)};

  always_comb begin
    busy_d  = busy_q;
    sck_d   = sck_q;
    cyc_d   = cyc_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    lane_d  = lane_q;
    addr4_d = addr4_q;
    fast_d  = fast_q;
    if (start_i && !busy_q) begin
      busy_d  = 1'b1;
      sck_d   = 1'b0;
      cyc_d   = '0;
      rx_d    = '0;
      lane_d  = lane_i;
      addr4_d = addr4_i;
      fast_d  = fast_i;
      tx_d    = addr4_i ? {opcode_i, addr_i} : {opcode_i, addr_i[23:0], 8'h00};
    end else if (rise) begin
      sck_d = 1'b1;
      if (cyc_q >= dstart) begin
        case (lane_q)
          LANE_X4: rx_d = {rx_q[3:0], io_in_i};
          LANE_X2: rx_d = {rx_q[5:0], io_in_i[1:0]};
          default: rx_d = {rx_q[6:0], io_in_i[1]};
        endcase
      end
    end else if (fall) begin
      sck_d = 1'b0;
      if (cyc_q == last) begin
        busy_d = 1'b0;
      end else begin
        cyc_d = cyc_q + 7'd1;
        tx_d  = {tx_q[38:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      sck_q   <= 1'b0;
      cyc_q   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      lane_q  <= LANE_X1;
      addr4_q <= 1'b0;
      fast_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      sck_q   <= sck_d;
      cyc_q   <= cyc_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      lane_q  <= lane_d;
      addr4_q <= addr4_d;
      fast_q  <= fast_d;
    end
  end
endmodule

// File: rtl/sfr_read_engine.sv
module sfr_read_engine
  import sfr_pkg::*;
#(
  parameter int unsigned CLK_DIV = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_we_i,
  input  logic [7:0] bus_addr_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o,
  output logic       flash_sck_o,
  output logic       flash_cs_n_o,
  output logic [3:0] flash_io_o,
  output logic [3:0] flash_io_oe_o,
  input  logic [3:0] flash_io_i
);
  logic [1:0]  rst_sync_q;
  logic        rst_n_int;
  logic        start, busy, done, tick, addr4, fast;
  lane_e       lane;
  logic [7:0]  opcode, rx_byte;
  logic [31:0] cur_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  sfr_regs #(.AW(32)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_n_int),
    .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .busy_i(busy), .done_i(done), .rx_byte_i(rx_byte),
    .start_o(start), .lane_o(lane), .addr4_o(addr4), .fast_o(fast),
    .opcode_o(opcode), .addr_o(cur_addr)
  );

  sfr_tick #(.DIV(CLK_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_n_int), .run_i(busy), .tick_o(tick)
  );

  sfr_xfer u_xfer (
    .clk_i(clk_i), .rst_ni(rst_n_int), .start_i(start), .tick_i(tick),
    .lane_i(lane), .addr4_i(addr4), .fast_i(fast), .opcode_i(opcode),
    .addr_i(cur_addr), .io_in_i(flash_io_i), .busy_o(busy), .done_o(done),
    .rx_byte_o(rx_byte), .sck_o(flash_sck_o), .cs_n_o(flash_cs_n_o),
    .io_out_o(flash_io_o), .io_oe_o(flash_io_oe_o)
  );
endmodule

// File: rtl/sfr_read_engine_chk.sv
module sfr_read_engine_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bus_we_i,
  input logic [7:0]  bus_addr_i,
  input logic [7:0]  bus_wdata_i,
  input logic        busy,
  input logic        cs_n,
  input logic        sck,
  input logic [3:0]  io_oe,
  input logic [31:0] cur_addr
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n |-> (!sck && io_oe == 4'b0000)); // R9

  AST_CS_FOLLOWS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n |-> busy); // R3

  AST_START_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == 8'h00 && bus_wdata_i == 8'h81 && !busy) |=> busy); // R2

  AST_OTHER_CMD_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == 8'h00 && bus_wdata_i != 8'h81 && !busy) |=> !busy); // R2

  AST_ADDR_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> (cur_addr == $past(cur_addr) + 32'd1)); // R8

  AST_SINGLE_DRIVE_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(io_oe) && io_oe[3:1] == 3'b000); // R9
endmodule

bind sfr_read_engine sfr_read_engine_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_we_i(bus_we_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
  .busy(busy), .cs_n(flash_cs_n_o), .sck(flash_sck_o),
  .io_oe(flash_io_oe_o), .cur_addr(cur_addr)
);

// File: tb/sfr_read_engine_bench.sv
`timescale 1ns/1ps
module sfr_read_engine_bench;
  logic       clk, rst_n, we;
  logic [7:0] addr, wdata, rdata;
  logic       sck, cs_n;
  logic [3:0] io_o, io_oe, io_i;

  sfr_read_engine #(.CLK_DIV(2)) u_sfr_read_engine (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .flash_sck_o(sck),
    .flash_cs_n_o(cs_n), .flash_io_o(io_o), .flash_io_oe_o(io_oe),
    .flash_io_i(io_i)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    logic [7:0]  op;
    logic [31:0] adr;
    bit          a4;
    int          total;
  } exp_t;
  exp_t exp_q[$];

  int          cfg_lane = 0;   // 0 single, 1 dual, 2 quad
  bit          cfg_a4 = 0;
  bit          cfg_fast = 0;
  logic [31:0] cfg_addr = '0;
  int          edge_cnt = 0;
  logic [63:0] cap = '0;

  function automatic logic [7:0] flash_byte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'hA5;
  endfunction

  function automatic int abits_now();
    return cfg_a4 ? 32 : 24;
  endfunction

  task automatic check(input bit ok, input string req, input logic [39:0] act,
                       input logic [39:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // flash model
  always @(negedge cs_n) begin
    edge_cnt = 0;
    cap = '0;
  end
  always @(posedge sck) begin
    if (edge_cnt < 8 + abits_now()) cap = {cap[62:0], io_o[0]};
    edge_cnt = edge_cnt + 1;
  end
  always_comb begin
    int dst;
    int j;
    logic [7:0] b;
    dst = 8 + abits_now() + (cfg_fast ? 8 : 0);
    j = edge_cnt - dst;
    b = flash_byte(cfg_addr);
    io_i = 4'b0000;
    if (j >= 0) begin
      if (cfg_lane == 2 && j < 2)      io_i = b[7-4*j -: 4];
      else if (cfg_lane == 1 && j < 4) io_i[1:0] = b[7-2*j -: 2];
      else if (cfg_lane == 0 && j < 8) io_i[1] = b[7-j];
    end
  end

  // monitor: compares the serial command phase when chip select rises
  always @(posedge cs_n) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      if (e.a4) check(cap[39:0] == {e.op, e.adr}, "R4/R6 cmd+addr32",
                      cap[39:0], {e.op, e.adr});
      else check(cap[31:0] == {e.op, e.adr[23:0]}, "R4/R6 cmd+addr24",
                 {8'h0, cap[31:0]}, {8'h0, e.op, e.adr[23:0]});
      check(edge_cnt == e.total, "R7 sck edge count", 40'(edge_cnt), 40'(e.total));
      check(sck == 1'b0, "R9 sck low at cs rise", 40'(sck), 40'd0);
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic setup(input logic [7:0] mode, input bit fast, input int lane,
                       input bit a4, input logic [31:0] a);
    bus_wr(8'h01, mode);
    bus_wr(8'h02, {7'b0, fast});
    for (int i = 0; i < 4; i++) bus_wr(8'h08 + 8'(i), a[8*i +: 8]);
    cfg_lane = lane; cfg_a4 = a4; cfg_fast = fast;
  endtask

  task automatic do_read(input logic [7:0] op, input logic [31:0] a, input string req);
    logic [7:0] d;
    exp_t e;
    cfg_addr = a;
    e.op = op; e.adr = a; e.a4 = cfg_a4;
    e.total = 8 + abits_now() + (cfg_fast ? 8 : 0) +
              (cfg_lane == 2 ? 2 : (cfg_lane == 1 ? 4 : 8));
    exp_q.push_back(e);
    bus_wr(8'h00, 8'h81);
    bus_rd(8'h00, d);
    check(d == 8'h01, "R3 busy bit set", 40'(d), 40'h01);
    for (int k = 0; k < 2000; k++) begin
      bus_rd(8'h00, d);
      if (d[0] == 1'b0) break;
    end
    check(d == 8'h00, "R3 busy bit cleared", 40'(d), 40'h00);
    bus_rd(8'h03, d);
    check(d == flash_byte(a), req, 40'(d), 40'(flash_byte(a)));
  endtask

  initial begin
    #750000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    we = 1'b0; addr = 8'h00; wdata = 8'h00; rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(cs_n == 1'b1, "R1 cs_n high", 40'(cs_n), 40'd1);
    check(sck == 1'b0, "R1 sck low", 40'(sck), 40'd0);
    check(io_oe == 4'b0, "R1 lane enables off", 40'(io_oe), 40'd0);
    bus_rd(8'h00, d);
    check(d == 8'h00, "R1 command reg idle", 40'(d), 40'd0);

    bus_wr(8'h04, 8'h03);
    bus_wr(8'h05, 8'h6B);

    // single lane, 24-bit, normal read, then auto-increment with carry
    setup(8'h00, 1'b0, 0, 1'b0, 32'h0012_34FE);
    do_read(8'h03, 32'h0012_34FE, "R5 single lane byte");
    do_read(8'h03, 32'h0012_34FF, "R8 consecutive byte");
    do_read(8'h03, 32'h0012_3500, "R8 carry into byte 1");
    bus_rd(8'h08, d);
    check(d == 8'h01, "R8 address byte0 readback", 40'(d), 40'h01);
    bus_rd(8'h09, d);
    check(d == 8'h35, "R8 address byte1 readback", 40'(d), 40'h35);

    // R2: other command codes start nothing
    bus_wr(8'h00, 8'h10);
    repeat (12) @(negedge clk);
    check(cs_n == 1'b1, "R2 code 0x10 ignored", 40'(cs_n), 40'd1);
    bus_wr(8'h00, 8'h01);
    bus_rd(8'h00, d);
    check(d == 8'h00 && cs_n, "R2 code 0x01 ignored", 40'(d), 40'd0);

    // R7 fast read single lane
    bus_wr(8'h04, 8'h0B);
    setup(8'h00, 1'b1, 0, 1'b0, 32'h00AB_CDEF);
    do_read(8'h0B, 32'h00AB_CDEF, "R7 fast single byte");

    // dual output, fast
    bus_wr(8'h04, 8'h3B);
    setup(8'h01, 1'b1, 1, 1'b0, 32'h0000_1357);
    do_read(8'h3B, 32'h0000_1357, "R5 dual lane byte");
    do_read(8'h3B, 32'h0000_1358, "R5 dual lane next byte");

    // quad output, opcode from second register
    setup(8'h04, 1'b1, 2, 1'b0, 32'h0055_AA10);
    do_read(8'h6B, 32'h0055_AA10, "R5 quad lane byte");

    // quad wins over dual when both set
    setup(8'h05, 1'b0, 2, 1'b0, 32'h0001_0203);
    do_read(8'h6B, 32'h0001_0203, "R5 quad priority byte");

    // R6 32-bit address, several modes
    setup(8'h14, 1'b1, 2, 1'b1, 32'hDEAD_BEEF);
    do_read(8'h6B, 32'hDEAD_BEEF, "R6 quad 32-bit addr byte");
    setup(8'h11, 1'b0, 1, 1'b1, 32'h01FF_FFFF);
    do_read(8'h3B, 32'h01FF_FFFF, "R6 dual 32-bit addr byte");
    setup(8'h10, 1'b0, 0, 1'b1, 32'h0200_0000);
    do_read(8'h3B, 32'h0200_0000, "R6 single 32-bit addr byte");
    bus_rd(8'h0B, d);
    check(d == 8'h02, "R8 address byte3 readback", 40'(d), 40'h02);

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R3 every command completed", 40'(exp_q.size()), 40'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule